// File: doc/BRIEF.md
# Shared Interrupt Controller for a Small Multiprocessor

This block collects interrupt sources for a system of two to four processors and presents one interrupt request line to each processor. Interrupt numbers fall into three bands: numbers 0 to 15 are raised by software, numbers 16 to 31 are private level lines that each processor owns separately, and numbers from 32 upward are shared level lines. Each shared line is steered to exactly one processor through its own routing register.

Software reaches the block through a word-wide register bus. One global window holds the controller-wide switch and the routing registers. Each processor then has a local window. Through that window the processor enables and disables interrupts by number, inspects or claims its best ready interrupt, signals completion and raises software interrupts on any set of processors. Priority is fixed: the lowest ready number wins. A claimed interrupt stays active, and is hidden from its processor, until the completion write arrives.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending software interrupt, active flag, routing register and control switch is clear, so `irq_out` is 0 and a claim returns the spurious code.
- R2: Number 16+k of processor c follows input `priv_irq[c*16+k]`, and shared number 32+j follows `com_irq[j]`. A private line never affects another processor.
- R3: Writing a number to local offset 0xA0 enables it and writing it to offset 0xA4 disables it. Private and software numbers are enabled per processor and shared numbers are enabled globally. A written value of NUM_IDS or above changes nothing.
- R4: A read of local offset 0x6C returns the lowest ready number for that processor and marks it active. Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R5: A claim made while nothing is ready returns 0xFFFFFFFF and changes no state.
- R6: A read of local offset 0x68 returns bit 31 set when an interrupt is ready and the lowest ready number in bits [5:0] (zero when none is ready). It has no side effect.
- R7: An active interrupt is not offered to its processor again until its number is written to local offset 0xB4, which clears the active flag.
- R8: The routing register of shared number n sits at global offset 0x1000 + 4*(n-32). Bit 31 is the valid flag and bits [1:0] are the target processor index. An interrupt with the valid flag clear is never delivered, and no shared number is ever ready at two processors at once. The register reads back the same two fields.
- R9: A write to local offset 0x60 makes software number bits[3:0] pending at every processor c whose bit 8+c is set. The pending state is cleared when that number is claimed.
- R10: `irq_out[c]` is high exactly when global offset 0x0 bit 0 is set, processor c's local offset 0x0 bit 0 is set, and c has a ready interrupt. Both control bits read back.
- R11: Processor n's local window starts at 0x8000 + n*0x1000. Windows for indices at or above NUM_CPU read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |
| bus_rvalid | output | 1 | Marks the cycle in which bus_rdata is valid |
| priv_irq | input | NUM_CPU*16 | Private level lines, 16 per processor |
| com_irq | input | NUM_IDS-32 | Shared level lines |
| irq_out | output | NUM_CPU | Interrupt request to each processor |

## Verification
A wrong enable, active or routing bit becomes visible at the ports within one cycle. It shows either on `irq_out` or in the next peek or claim read, as a wrong number or as a number that is still offered after it was claimed. A lost software-pending bit or a flag that is wrongly cleared shows as an `irq_out` edge that does not come, or comes too soon, after the write that should have caused it. Random routing and shared-line patterns are compared against a peek and claim model, so a routing fault that lands a shared number at two processors, or at none, is exposed.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int SGI_N    = 16;
    localparam int PRIV_N   = 16;
    localparam int LOCAL_N  = 32;
    localparam int COM_BASE = 32;

    localparam logic [11:0] OFF_CTRL  = 12'h000;
    localparam logic [11:0] OFF_SGI   = 12'h060;
    localparam logic [11:0] OFF_PEEK  = 12'h068;
    localparam logic [11:0] OFF_CLAIM = 12'h06C;
    localparam logic [11:0] OFF_EN    = 12'h0A0;
    localparam logic [11:0] OFF_DIS   = 12'h0A4;
    localparam logic [11:0] OFF_DONE  = 12'h0B4;

    localparam logic [DATA_W-1:0] SPURIOUS = '1;

    typedef struct packed {
        logic       vld;
        logic [1:0] cpu;
    } dest_t;

endpackage

// File: rtl/mp_irq_elig.sv
module mp_irq_elig
    import mpic_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int CPU_IDX = 0
) (
    input  logic [SGI_N-1:0]              sgi_pend,
    input  logic [PRIV_N-1:0]             priv_lvl,
    input  logic [LOCAL_N-1:0]            loc_en,
    input  logic [LOCAL_N-1:0]            loc_act,
    input  logic [NUM_IDS-COM_BASE-1:0]   com_lvl,
    input  logic [NUM_IDS-COM_BASE-1:0]   com_en,
    input  logic [NUM_IDS-COM_BASE-1:0]   com_act,
    input  dest_t [NUM_IDS-COM_BASE-1:0]  dest,
    output logic [NUM_IDS-1:0]            elig
);
    localparam int NCOM = NUM_IDS - COM_BASE;

    assign elig[LOCAL_N-1:0] = {priv_lvl, sgi_pend} & loc_en & ~loc_act;

    for (genvar j = 0; j < NCOM; j++) begin : g_com
        assign elig[COM_BASE+j] = com_lvl[j] & com_en[j] & ~com_act[j]
                                & dest[j].vld & (dest[j].cpu == 2'(CPU_IDX));
    end

endmodule

// File: rtl/mp_irq_pick.sv
module mp_irq_pick #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         vec,
    output logic                 found,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] id
);
    localparam int W = $clog2(N);

    assign found = |vec;
    assign grant = vec & (~vec + N'(1));

    always_comb begin
        id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) id = W'(i);
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        found |-> (grant[id] && $onehot0(grant) && ((vec & ((N'(1) << id) - N'(1))) == '0))); // R4

endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mpic_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IDS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          bus_rvalid,
    input  logic [NUM_CPU*PRIV_N-1:0]     priv_irq,
    input  logic [NUM_IDS-COM_BASE-1:0]   com_irq,
    output logic [NUM_CPU-1:0]            irq_out
);
    localparam int NCOM = NUM_IDS - COM_BASE;
    localparam int ID_W = $clog2(NUM_IDS);

    // architectural state
    logic                              dist_en_q;
    logic [NUM_CPU-1:0]                cpu_en_q;
    logic [NUM_CPU-1:0][SGI_N-1:0]     sgi_q;
    logic [NUM_CPU-1:0][LOCAL_N-1:0]   len_q, lact_q;
    logic [NCOM-1:0]                   cen_q, cact_q;
    dest_t [NCOM-1:0]                  dest_q;

    // decode
    logic              wr, rd, glb_ctrl, glb_dest, claim_rd;
    logic [11:0]       off;
    logic [9:0]        dsel;
    logic [NUM_CPU-1:0] lsel;
    logic [NUM_IDS-1:0] id_oh;
    logic [SGI_N-1:0]  sgi_oh;

    always_comb begin
        wr       = bus_valid & bus_write;
        rd       = bus_valid & ~bus_write;
        off      = bus_addr[11:0];
        dsel     = bus_addr[11:2];
        glb_ctrl = ~bus_addr[15] && (bus_addr[14:0] == '0);
        glb_dest = ~bus_addr[15] && (bus_addr[14:12] == 3'd1) && (bus_addr[1:0] == 2'b00)
                   && (int'(dsel) < NCOM);
        for (int c = 0; c < NUM_CPU; c++)
            lsel[c] = bus_addr[15] && !bus_addr[14] && (bus_addr[13:12] == 2'(c));
        for (int i = 0; i < NUM_IDS; i++)
            id_oh[i] = (bus_wdata == DATA_W'(i));
        sgi_oh   = SGI_N'(1) << bus_wdata[3:0];
        claim_rd = rd && (|lsel) && (off == OFF_CLAIM);
    end

    // per-processor eligibility and selection
    logic [NUM_CPU-1:0][NUM_IDS-1:0] elig, grant;
    logic [NUM_CPU-1:0][ID_W-1:0]    rid;
    logic [NUM_CPU-1:0]              ready;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        mp_irq_elig #(.NUM_IDS(NUM_IDS), .CPU_IDX(c)) u_elig (
            .sgi_pend (sgi_q[c]),
            .priv_lvl (priv_irq[c*PRIV_N +: PRIV_N]),
            .loc_en   (len_q[c]),
            .loc_act  (lact_q[c]),
            .com_lvl  (com_irq),
            .com_en   (cen_q),
            .com_act  (cact_q),
            .dest     (dest_q),
            .elig     (elig[c])
        );
        mp_irq_pick #(.N(NUM_IDS)) u_pick (
            .clk   (clk),
            .rst   (rst),
            .vec   (elig[c]),
            .found (ready[c]),
            .grant (grant[c]),
            .id    (rid[c])
        );
        assign irq_out[c] = dist_en_q & cpu_en_q[c] & ready[c];
    end

    // read multiplexer
    logic              sel_ready, sel_cpu_en;
    logic [ID_W-1:0]   sel_id;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        sel_ready  = 1'b0;
        sel_cpu_en = 1'b0;
        sel_id     = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (lsel[c]) begin
                sel_ready  = ready[c];
                sel_cpu_en = cpu_en_q[c];
                sel_id     = rid[c];
            end
        end
        rd_mux = '0;
        if (glb_ctrl) begin
            rd_mux = {31'b0, dist_en_q};
        end else if (glb_dest) begin
            for (int j = 0; j < NCOM; j++)
                if (dsel == 10'(j)) rd_mux = {dest_q[j].vld, 29'b0, dest_q[j].cpu};
        end else if (|lsel) begin
            case (off)
                OFF_CTRL:  rd_mux = {31'b0, sel_cpu_en};
                OFF_PEEK:  rd_mux = {sel_ready, 31'(sel_id)};
                OFF_CLAIM: rd_mux = sel_ready ? DATA_W'(sel_id) : SPURIOUS;
                default:   rd_mux = '0;
            endcase
        end
    end

    // state update
    always_ff @(posedge clk) begin
        if (rst) begin
            dist_en_q  <= 1'b0;
            cpu_en_q   <= '0;
            sgi_q      <= '0;
            len_q      <= '0;
            lact_q     <= '0;
            cen_q      <= '0;
            cact_q     <= '0;
            dest_q     <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd;
            if (rd) bus_rdata <= rd_mux;
            if (wr && glb_ctrl) dist_en_q <= bus_wdata[0];
            for (int j = 0; j < NCOM; j++)
                if (wr && glb_dest && dsel == 10'(j))
                    dest_q[j] <= '{vld: bus_wdata[31], cpu: bus_wdata[1:0]};
            for (int c = 0; c < NUM_CPU; c++) begin
                if (lsel[c] && wr) begin
                    case (off)
                        OFF_CTRL: cpu_en_q[c] <= bus_wdata[0];
                        OFF_EN: begin
                            len_q[c] <= len_q[c] | id_oh[LOCAL_N-1:0];
                            cen_q    <= cen_q | id_oh[NUM_IDS-1:COM_BASE];
                        end
                        OFF_DIS: begin
                            len_q[c] <= len_q[c] & ~id_oh[LOCAL_N-1:0];
                            cen_q    <= cen_q & ~id_oh[NUM_IDS-1:COM_BASE];
                        end
                        OFF_DONE: begin
                            lact_q[c] <= lact_q[c] & ~id_oh[LOCAL_N-1:0];
                            cact_q    <= cact_q & ~id_oh[NUM_IDS-1:COM_BASE];
                        end
                        default: ;
                    endcase
                end else if (lsel[c] && claim_rd) begin
                    lact_q[c] <= lact_q[c] | grant[c][LOCAL_N-1:0];
                    cact_q    <= cact_q | grant[c][NUM_IDS-1:COM_BASE];
                    sgi_q[c]  <= sgi_q[c] & ~grant[c][SGI_N-1:0];
                end
                if (wr && (|lsel) && off == OFF_SGI && bus_wdata[8+c])
                    sgi_q[c] <= sgi_q[c] | sgi_oh;
            end
        end
    end

    // assertions
    AST_EMPTY_CLAIM_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        claim_rd && !sel_ready |=> bus_rdata == SPURIOUS); // R5

    AST_DIST_OFF_SILENCES: assert property (@(posedge clk) disable iff (rst)
        wr && glb_ctrl && !bus_wdata[0] |=> irq_out == '0); // R10

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk_cpu
        AST_CLAIM_NOT_REOFFERED: assert property (@(posedge clk) disable iff (rst)
            rd && lsel[c] && off == OFF_CLAIM && ready[c] |=> (elig[c] & $past(grant[c])) == '0); // R7
        AST_SGI_LATCHED: assert property (@(posedge clk) disable iff (rst)
            wr && (|lsel) && off == OFF_SGI && bus_wdata[8+c] |=> sgi_q[c][$past(bus_wdata[3:0])]); // R9
    end

    for (genvar j = 0; j < NCOM; j++) begin : g_chk_com
        logic [NUM_CPU-1:0] tgt;
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_t
            assign tgt[c] = elig[c][COM_BASE+j];
        end
        AST_COMMON_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
            $countones(tgt) <= 1); // R8
    end

endmodule

// File: tb/test_mp_irq_ctrl.sv
`timescale 1ns/1ps
module test_mp_irq_ctrl;
    localparam int NCPU = 2;
    localparam int NIDS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NCPU*16-1:0] priv_irq = '0;
    logic [NIDS-33:0]   com_irq = '0;
    logic [NCPU-1:0]    irq_out;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic        dvld [32];
    logic [1:0]  dcpu [32];

    always #2.5 clk = ~clk;

    mp_irq_ctrl #(.NUM_CPU(NCPU), .NUM_IDS(NIDS)) i_mp_irq_ctrl (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .priv_irq(priv_irq), .com_irq(com_irq), .irq_out(irq_out)
    );

    function automatic logic [15:0] loc(int c, logic [11:0] o);
        return 16'h8000 + 16'(c) * 16'h1000 + {4'b0, o};
    endfunction

    function automatic logic [31:0] exp_peek(int c);
        for (int j = 0; j < 32; j++)
            if (com_irq[j] && dvld[j] && dcpu[j] == 2'(c)) return 32'h8000_0000 | 32'(32 + j);
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        n_chk++;
        if (bus_rvalid !== 1'b1) begin
            n_err++;
            $display("FAIL R4 rvalid got=%b exp=1", bus_rvalid);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();

        // R1 reset state
        chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd(loc(0, 12'h06C), v); chk("R1 R5 claim after reset", v, 32'hFFFF_FFFF);
        rd(loc(1, 12'h068), v); chk("R1 R6 peek after reset", v, 32'h0);
        rd(16'h1000, v);        chk("R1 dest after reset", v, 32'h0);
        rd(16'h0000, v);        chk("R1 dist ctrl after reset", v, 32'h0);

        // R10 control readback
        wr(16'h0000, 32'h1);
        wr(loc(0, 12'h000), 32'h1);
        wr(loc(1, 12'h000), 32'h1);
        rd(16'h0000, v);        chk("R10 dist ctrl readback", v, 32'h1);
        rd(loc(1, 12'h000), v); chk("R10 cpu1 ctrl readback", v, 32'h1);
        rd(16'hA000, v);        chk("R11 window beyond NUM_CPU", v, 32'h0);

        // R9 software interrupts
        wr(loc(0, 12'h060), (32'h02 << 8) | 32'd5);
        chk("R3 sgi not yet enabled", 32'(irq_out), 32'h0);
        wr(loc(1, 12'h0A0), 32'd5);
        chk("R9 sgi reaches cpu1 only", 32'(irq_out), 32'h2);
        rd(loc(1, 12'h068), v); chk("R6 peek sgi", v, 32'h8000_0005);
        rd(loc(1, 12'h068), v); chk("R6 peek has no side effect", v, 32'h8000_0005);
        rd(loc(1, 12'h06C), v); chk("R4 claim sgi", v, 32'd5);
        chk("R9 claim clears sgi", 32'(irq_out), 32'h0);
        wr(loc(0, 12'h060), (32'h02 << 8) | 32'd5);
        chk("R7 active sgi hidden", 32'(irq_out), 32'h0);
        wr(loc(1, 12'h0B4), 32'd5);
        chk("R7 completion re-offers", 32'(irq_out), 32'h2);
        rd(loc(1, 12'h06C), v); chk("R9 second sgi claim", v, 32'd5);
        wr(loc(1, 12'h0B4), 32'd5);
        chk("R9 nothing left", 32'(irq_out), 32'h0);

        // R2 private lines
        wr(loc(0, 12'h0A0), 32'd20);
        priv_irq = '0; priv_irq[16 + 4] = 1'b1;
        settle();
        chk("R2 cpu1 line does not reach cpu0", 32'(irq_out), 32'h0);
        priv_irq = '0; priv_irq[2] = 1'b1; priv_irq[4] = 1'b1;
        settle();
        chk("R2 cpu0 line 20", 32'(irq_out), 32'h1);
        wr(loc(0, 12'h0A0), 32'd82);
        rd(loc(0, 12'h068), v); chk("R3 out-of-range enable ignored", v, 32'h8000_0014);
        wr(loc(0, 12'h0A0), 32'd18);
        rd(loc(0, 12'h06C), v); chk("R4 lowest wins", v, 32'd18);
        rd(loc(0, 12'h068), v); chk("R7 claimed 18 hidden", v, 32'h8000_0014);
        wr(loc(0, 12'h0B4), 32'd18);
        rd(loc(0, 12'h068), v); chk("R7 18 back after completion", v, 32'h8000_0012);
        priv_irq[2] = 1'b0;
        rd(loc(0, 12'h068), v); chk("R2 level line dropped", v, 32'h8000_0014);
        wr(loc(0, 12'h0A4), 32'd20);
        chk("R3 disable", 32'(irq_out), 32'h0);
        priv_irq = '0;

        // R8 routing
        com_irq[8] = 1'b1;
        wr(loc(0, 12'h0A0), 32'd40);
        chk("R8 invalid route not delivered", 32'(irq_out), 32'h0);
        wr(16'h1020, 32'h8000_0001);
        chk("R8 routed to cpu1", 32'(irq_out), 32'h2);
        rd(16'h1020, v);        chk("R8 dest readback", v, 32'h8000_0001);
        rd(loc(1, 12'h06C), v); chk("R4 claim common", v, 32'd40);
        chk("R7 common active", 32'(irq_out), 32'h0);
        wr(loc(1, 12'h0B4), 32'd40);
        chk("R7 common completion", 32'(irq_out), 32'h2);
        wr(16'h1020, 32'h8000_0000);
        chk("R8 retarget cpu0", 32'(irq_out), 32'h1);
        wr(16'h0000, 32'h0);
        chk("R10 distributor off", 32'(irq_out), 32'h0);
        wr(16'h0000, 32'h1);
        chk("R10 distributor on", 32'(irq_out), 32'h1);
        wr(loc(0, 12'h000), 32'h0);
        chk("R10 cpu0 interface off", 32'(irq_out), 32'h0);
        wr(loc(0, 12'h000), 32'h1);
        wr(loc(2, 12'h000), 32'h1);
        rd(loc(0, 12'h000), v); chk("R11 cpu0 ctrl unaffected", v, 32'h1);
        com_irq = '0;

        // random routing and shared lines
        for (int j = 0; j < 32; j++) wr(loc(0, 12'h0A0), 32'(32 + j));
        for (int it = 0; it < 15; it++) begin
            for (int j = 0; j < 32; j++) begin
                dvld[j] = 1'($urandom % 2);
                dcpu[j] = 2'($urandom % 4);
                wr(16'h1000 + 16'(4 * j), {dvld[j], 29'b0, dcpu[j]});
            end
            com_irq = $urandom;
            for (int c = 0; c < NCPU; c++) begin
                logic [31:0] e;
                e = exp_peek(c);
                rd(loc(c, 12'h068), v); chk("R8 R6 random peek", v, e);
                rd(loc(c, 12'h06C), v);
                chk("R4 R5 random claim", v, e[31] ? {1'b0, e[30:0]} : 32'hFFFF_FFFF);
                if (e[31]) wr(loc(c, 12'h0B4), {1'b0, e[30:0]});
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule